// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block is the digital heart of a processor supervisor. It merges every cause of reset into one pair of complementary reset outputs: a synchronous power-good flag from an external comparator, a filtered active-low manual reset button, and a watchdog that expires when software stops strobing it. Whenever the last cause goes away, the outputs stay asserted for a fixed stretch so that the supply and the processor can settle.

All timing is counted in ticks of a 1 ms clock enable (`tick_1ms`). The stretch is 250 ticks, the button filter 20 ticks, and the watchdog period is picked by a two-bit select from 150, 610 or 1200 ticks. The watchdog cannot be switched off. It is restarted only by a falling edge of the strobe, and it ignores the strobe while reset is asserted. A single stretch timer serves every cause, and the watchdog reloads its period each time a stretch ends.

Top module: `sup_reset_ctrl`

## Requirements
- R1: Reset asserts on the clock edge after `pwr_good` goes low, without filtering, and stays asserted while it is low.
- R2: Once every cause has cleared, `rst_out` stays high for STRETCH_TICKS (250) ticks and then drops.
- R3: Each new drop of `pwr_good` restarts the stretch count from zero.
- R4: While `rst_n` is low and for STRETCH_TICKS ticks after it is released (power-up), `rst_out` is high.
- R5: The watchdog period comes from `wd_sel`: 2'b00 gives 150 ticks, 2'b01 gives 610, 2'b10 gives 1200, and the reserved code 2'b11 gives 1200.
- R6: Only a high-to-low transition of `wd_strobe` restarts the watchdog; holding the strobe low does not keep restarting it.
- R7: Strobes are ignored while reset is asserted, and the watchdog loads the selected period at the end of every stretch.
- R8: A watchdog expiry raises reset for a fresh full stretch, after which the watchdog reloads.
- R9: `mr_n` must be low for DEBOUNCE_TICKS (20) ticks before it causes reset; shorter low pulses have no effect.
- R10: `rst_out_n` is always the exact complement of `rst_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously; models power-up |
| tick_1ms | input | 1 | One-cycle time-base enable, once per millisecond |
| pwr_good | input | 1 | Synchronous supply-in-tolerance flag, high when good |
| mr_n | input | 1 | Asynchronous active-low manual reset button |
| wd_strobe | input | 1 | Asynchronous watchdog strobe, falling edge restarts |
| wd_sel | input | 2 | Watchdog period select |
| rst_out | output | 1 | Active-high system reset |
| rst_out_n | output | 1 | Active-low system reset |

## Verification
A corrupted stretch counter shows as a reset that releases early or late against the 250-tick window, visible within one stretch. A wrong watchdog count or period decode shows as a reset arriving before the next strobe of a well-behaved program, or missing after a silent gap, within one watchdog period. A faulty edge detector or button filter shows as a missed or spurious reset within one period or one 20-tick filter window.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    WD_SHORT = 2'b00,
    WD_MID   = 2'b01,
    WD_LONG  = 2'b10,
    WD_RSVD  = 2'b11
  } wd_sel_e;
endpackage

// File: rtl/sup_sync2.sv
module sup_sync2 #(
  parameter int        W  = 1,
  parameter logic      RV = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= {W{RV}};
      q    <= {W{RV}};
    end else begin
      s1_q <= d;
      q    <= s1_q;
    end
  end
endmodule

// File: rtl/sup_mr_filter.sv
module sup_mr_filter #(
  parameter int DEBOUNCE_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic mr_s_n,
  output logic mr_act
);
  localparam int DW = (DEBOUNCE_TICKS > 1) ? $clog2(DEBOUNCE_TICKS) : 1;

  logic [DW-1:0] cnt_q, cnt_d;
  logic          act_d;

  always_comb begin
    cnt_d = cnt_q;
    act_d = mr_act;
    if (mr_s_n) begin
      cnt_d = '0;
      act_d = 1'b0;
    end else if (tick && !mr_act) begin
      if (cnt_q == DW'(DEBOUNCE_TICKS - 1)) begin
        cnt_d = '0;
        act_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mr_act <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      mr_act <= act_d;
    end
  end

  // R9: acceptance only after a full low window closed on a tick
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mr_act) |-> ($past(tick) && $past(cnt_q) == DW'(DEBOUNCE_TICKS - 1)));
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mr_s_n |=> !mr_act);
endmodule

// File: rtl/sup_wd.sv
module sup_wd #(
  parameter int P_SHORT = 150,
  parameter int P_MID   = 610,
  parameter int P_LONG  = 1200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       st_s,
  input  logic       rst_act,
  input  logic [1:0] sel,
  output logic       wd_exp
);
  import sup_pkg::*;
  localparam int WW = $clog2(P_LONG + 1);

  logic [WW-1:0] cnt_q, cnt_d, per;
  logic          st_prev_q, fall, exp_d;
  wd_sel_e       sel_e;

  assign sel_e = wd_sel_e'(sel);
  assign fall  = st_prev_q & ~st_s;

  always_comb begin
    case (sel_e)
      WD_SHORT: per = WW'(P_SHORT);
      WD_MID:   per = WW'(P_MID);
      default:  per = WW'(P_LONG);
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    exp_d = 1'b0;
    if (rst_act || fall) begin
      cnt_d = per;
    end else if (tick) begin
      if (cnt_q <= WW'(1)) begin
        exp_d = 1'b1;
        cnt_d = per;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      st_prev_q <= 1'b1;
      wd_exp    <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      st_prev_q <= st_s;
      wd_exp    <= exp_d;
    end
  end

  // R7: no expiry can follow a cycle spent in reset
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_act |=> !wd_exp);
  // R8: after an expiry the counter holds a full period again
  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_exp |-> (cnt_q == $past(per)));
  // R5: counter only moves on a tick, a restart or reset
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !rst_act && !fall) |=> $stable(cnt_q));
endmodule

// File: rtl/sup_stretch.sv
module sup_stretch #(
  parameter int STRETCH_TICKS = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cause,
  output logic rst_q
);
  localparam int SW = (STRETCH_TICKS > 1) ? $clog2(STRETCH_TICKS) : 1;

  logic [SW-1:0] scnt_q, scnt_d;
  logic          rst_d;

  always_comb begin
    scnt_d = scnt_q;
    rst_d  = rst_q;
    if (cause) begin
      scnt_d = '0;
      rst_d  = 1'b1;
    end else if (rst_q && tick) begin
      if (scnt_q == SW'(STRETCH_TICKS - 1)) begin
        scnt_d = '0;
        rst_d  = 1'b0;
      end else begin
        scnt_d = scnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt_q <= '0;
      rst_q  <= 1'b1;
    end else begin
      scnt_q <= scnt_d;
      rst_q  <= rst_d;
    end
  end

  p_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cause |=> rst_q);
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cause |=> (scnt_q == '0));
  p_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_q) |-> ($past(scnt_q) == SW'(STRETCH_TICKS - 1) && !$past(cause)));
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
  parameter int STRETCH_TICKS  = 250,
  parameter int DEBOUNCE_TICKS = 20,
  parameter int P_SHORT        = 150,
  parameter int P_MID          = 610,
  parameter int P_LONG         = 1200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1ms,
  input  logic       pwr_good,
  input  logic       mr_n,
  input  logic       wd_strobe,
  input  logic [1:0] wd_sel,
  output logic       rst_out,
  output logic       rst_out_n
);
  logic [1:0] raw_in, sync_out;
  logic       mr_s_n, st_s, mr_act, wd_exp, cause, rst_q;

  assign raw_in = {mr_n, wd_strobe};

  sup_sync2 #(.W(2), .RV(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );
  assign mr_s_n = sync_out[1];
  assign st_s   = sync_out[0];

  sup_mr_filter #(.DEBOUNCE_TICKS(DEBOUNCE_TICKS)) u_mr (
    .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .mr_s_n(mr_s_n), .mr_act(mr_act)
  );

  sup_wd #(.P_SHORT(P_SHORT), .P_MID(P_MID), .P_LONG(P_LONG)) u_wd (
    .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .st_s(st_s),
    .rst_act(rst_q), .sel(wd_sel), .wd_exp(wd_exp)
  );

  assign cause = ~pwr_good | mr_act | wd_exp;

  sup_stretch #(.STRETCH_TICKS(STRETCH_TICKS)) u_str (
    .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .cause(cause), .rst_q(rst_q)
  );

  assign rst_out   = rst_q;
  assign rst_out_n = ~rst_q;

  // R1: a power-good drop is seen at the output one edge later
  p_pwr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> rst_out);
  // R8: an expiry is followed by an asserted reset
  p_exp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_exp |=> rst_out);
endmodule

// File: tb/tb_sup_reset_ctrl.sv
module tb_sup_reset_ctrl;
  logic       clk = 1'b0;
  logic       rst_n, tick_1ms, pwr_good, mr_n, wd_strobe;
  logic [1:0] wd_sel;
  logic       rst_out, rst_out_n;

  int checks = 0;
  int errors = 0;
  bit seen;
  bit compl_bad = 1'b0;

  always #10 clk = ~clk;

  initial tick_1ms = 1'b0;
  always @(negedge clk) tick_1ms <= rst_n ? ~tick_1ms : 1'b0;

  sup_reset_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .pwr_good(pwr_good),
    .mr_n(mr_n), .wd_strobe(wd_strobe), .wd_sel(wd_sel),
    .rst_out(rst_out), .rst_out_n(rst_out_n)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic [15:0] gap;
    logic        exp_rst;
  } vec_t;

  // R5 table: strobe gap just inside and just outside each period
  localparam vec_t TBL [8] = '{
    '{2'b00, 16'd145,  1'b0}, '{2'b00, 16'd156,  1'b1},
    '{2'b01, 16'd604,  1'b0}, '{2'b01, 16'd616,  1'b1},
    '{2'b10, 16'd1194, 1'b0}, '{2'b10, 16'd1206, 1'b1},
    '{2'b11, 16'd1194, 1'b0}, '{2'b11, 16'd1206, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance n ticks (two cycles each), watching the outputs at negedges
  task automatic run(input int n);
    for (int i = 0; i < 2 * n; i++) begin
      @(negedge clk);
      if (rst_out) seen = 1'b1;
      if (rst_out_n !== ~rst_out) compl_bad = 1'b1;
    end
  endtask

  task automatic strobe_pulse();
    wd_strobe = 1'b0;
    run(1);
    wd_strobe = 1'b1;
  endtask

  task automatic wait_clear();
    for (int i = 0; i < 2000 && rst_out; i++) run(1);
    run(2);
  endtask

  initial begin
    rst_n = 1'b0; pwr_good = 1'b1; mr_n = 1'b1; wd_strobe = 1'b1; wd_sel = 2'b00;
    repeat (4) @(negedge clk);
    chk(rst_out == 1'b1 && rst_out_n == 1'b0, "R4 reset state", rst_out, 1);
    rst_n = 1'b1;
    run(245);
    chk(rst_out == 1'b1, "R4 power-up stretch held", rst_out, 1);
    run(10);
    chk(rst_out == 1'b0, "R2 power-up stretch ends", rst_out, 0);

    // R1 immediate power-good response, R3 restart
    pwr_good = 1'b0;
    @(negedge clk);
    chk(rst_out == 1'b1, "R1 power-good low asserts next edge", rst_out, 1);
    run(5);
    pwr_good = 1'b1;
    run(200);
    pwr_good = 1'b0;
    run(1);
    pwr_good = 1'b1;
    run(200);
    chk(rst_out == 1'b1, "R3 stretch restarted by second drop", rst_out, 1);
    run(55);
    chk(rst_out == 1'b0, "R3 stretch ends after restart", rst_out, 0);

    // R9 short manual pulse rejected
    strobe_pulse();
    seen = 1'b0;
    mr_n = 1'b0;
    run(10);
    mr_n = 1'b1;
    run(5);
    chk(seen == 1'b0, "R9 short button pulse ignored", seen, 0);
    mr_n = 1'b0;
    run(17);
    chk(rst_out == 1'b0, "R9 not accepted before filter window", rst_out, 0);
    run(6);
    chk(rst_out == 1'b1, "R9 accepted after filter window", rst_out, 1);
    run(17);
    mr_n = 1'b1;
    run(245);
    chk(rst_out == 1'b1, "R2 held after button release", rst_out, 1);
    run(10);
    chk(rst_out == 1'b0, "R2 released after stretch", rst_out, 0);

    // R6 strobe held low does not keep restarting
    wd_strobe = 1'b0;
    run(100);
    chk(rst_out == 1'b0, "R6 single falling edge restarts", rst_out, 0);
    seen = 1'b0;
    run(56);
    chk(seen == 1'b1, "R6 held-low strobe lets watchdog expire", seen, 1);
    wd_strobe = 1'b1;

    // R7 strobes during reset ignored; period starts at stretch end
    for (int k = 0; k < 10; k++) begin
      run(10);
      wd_strobe = ~wd_strobe;
    end
    wd_strobe = 1'b1;
    for (int i = 0; i < 400 && rst_out; i++) run(1);
    seen = 1'b0;
    run(145);
    chk(seen == 1'b0, "R7 no early expiry after stretch end", seen, 0);
    begin
      int w = 0;
      while (!rst_out && w < 15) begin run(1); w++; end
    end
    chk(rst_out == 1'b1, "R7 expiry one period after stretch end", rst_out, 1);
    run(245);
    chk(rst_out == 1'b1, "R8 expiry gives full stretch (held)", rst_out, 1);
    run(10);
    chk(rst_out == 1'b0, "R8 expiry stretch ends", rst_out, 0);

    // R5 table walk
    foreach (TBL[i]) begin
      wd_sel = TBL[i].sel;
      wait_clear();
      seen = 1'b0;
      strobe_pulse();
      run(int'(TBL[i].gap));
      if (!TBL[i].exp_rst) begin
        strobe_pulse();
        run(int'(TBL[i].gap));
      end
      chk(seen == TBL[i].exp_rst, $sformatf("R5 sel=%0d gap=%0d", TBL[i].sel, TBL[i].gap),
          seen, TBL[i].exp_rst);
    end

    chk(compl_bad == 1'b0, "R10 outputs complementary", compl_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule